// File: doc/BRIEF.md
# Interrupt Controller with Shadow Pending Stage

This block gathers a bank of single-cycle event pulses into a set of byte-wide status registers and signals a host over one active-low interrupt line. Each event source has its own mask bit. A masked source is dropped at the input and never reaches any stored state.

Events never merge into status that the host has not yet acknowledged. While any status bit is still set, newly admitted events collect in a shadow pending register. The host reads the status registers first. It then writes any value to any one status address, which empties all status registers at once and releases the line. On the next cycle, any parked events move into status and the line falls again. An event that arrives during that move stays parked for the following round.

The host reaches the block through a flat register port with a single-cycle write strobe and a combinational read path.

Top module: `irq_shadow_ctrl`

## Requirements
- R1: After reset, every status, shadow and mask bit is 0 and `irq_n_o` is 1.
- R2: An unmasked event pulse, arriving while status and shadow are both empty, sets its status bit on the next rising edge, and `irq_n_o` goes to 0 in that cycle.
- R3: An event whose mask bit is 1 sets no status bit and no shadow bit. After a later clear, the promotion cycle shows it nowhere.
- R4: While any status bit is set and no clear is written, status holds its value and new unmasked events go to the shadow register.
- R5: Only a write to a status address (0, 1 or 2) empties all three status registers on that edge and drives `irq_n_o` to 1, whatever data is written. A write to an unmapped address changes nothing.
- R6: In the cycle after a clear, a non-empty shadow register is copied into status, the shadow register is emptied, and `irq_n_o` returns to 0.
- R7: An event arriving in the same cycle as a clear goes to shadow. An event arriving in the promotion cycle stays in shadow and is promoted only after the next clear.
- R8: `irq_n_o` is 0 exactly when some status bit has a mask bit of 0. Setting the mask after the bit is latched releases the line, and clearing the mask asserts it again.
- R9: Mask registers sit at addresses 3, 4 and 5 and read back the value written. Mask bit b at address 3+k gates event input 8k+b, and a 1 masks it.
- R10: Reading any register has no side effect on status, shadow or the line.
- R11: Event input i maps to status address i/8, bit i%8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 24 | Event pulses, one per source, sampled on the rising edge |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational); 0 for unmapped addresses |
| irq_n_o | output | 1 | Interrupt line to host, active low |

## Verification
The hardest situations to reach from the ports are events that land exactly on the clear edge, and events that land on the following promotion edge. Both are decided by single-cycle alignment between the write strobe and the event pulses. The bench steps one clock at a time from a known busy state. It raises one event together with the clear write and another on the very next cycle. It then reads the status registers after each of the two following clears to show which round each event landed in.

// File: rtl/irq_shadow_pkg.sv
package irq_shadow_pkg;

    parameter int unsigned DEF_BANKS = 3;
    parameter int unsigned DEF_WIDTH = 8;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_MASK   = 2'd1,
        REG_NONE   = 2'd2
    } reg_kind_e;

    // Status banks occupy [0, banks), mask banks [banks, 2*banks).
    function automatic reg_kind_e reg_kind(input int unsigned addr, input int unsigned banks);
        if (addr < banks)
            return REG_STATUS;
        else if (addr < 2 * banks)
            return REG_MASK;
        else
            return REG_NONE;
    endfunction

endpackage

// File: rtl/irq_shadow_mask.sv
module irq_shadow_mask
    import irq_shadow_pkg::*;
#(
    parameter int unsigned BANKS  = DEF_BANKS,
    parameter int unsigned WIDTH  = DEF_WIDTH,
    parameter int unsigned ADDR_W = $clog2(2 * BANKS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [WIDTH-1:0]            wdata_i,
    output logic [BANKS-1:0][WIDTH-1:0] mask_o
);

    logic [BANKS-1:0][WIDTH-1:0] mask_d, mask_q;
    logic [BANKS-1:0]            hit;

    for (genvar k = 0; k < BANKS; k++) begin : g_hit
        assign hit[k] = wr_i && (int'(addr_i) == int'(BANKS + k));
    end

    always_comb begin
        mask_d = mask_q;
        for (int k = 0; k < int'(BANKS); k++) begin
            if (hit[k])
                mask_d[k] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else
            mask_q <= mask_d;
    end

    assign mask_o = mask_q;

    // R9: a write to mask bank 0 is visible on the next cycle
    p_mask_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && int'(addr_i) == int'(BANKS)) |=> (mask_o[0] == $past(wdata_i)));

endmodule

// File: rtl/irq_shadow_event.sv
module irq_shadow_event #(
    parameter int unsigned N = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] mask_i,
    input  logic         clr_i,
    output logic [N-1:0] status_o
);

    typedef struct packed {
        logic [N-1:0] status;
        logic [N-1:0] shadow;
    } evt_state_t;

    evt_state_t st_d, st_q;
    logic [N-1:0] admit;

    always_comb begin
        admit = evt_i & ~mask_i;
        st_d  = st_q;
        if (clr_i) begin
            st_d.status = '0;
            st_d.shadow = st_q.shadow | admit;
        end else if (|st_q.status) begin
            st_d.shadow = st_q.shadow | admit;
        end else if (|st_q.shadow) begin
            st_d.status = st_q.shadow;
            st_d.shadow = admit;
        end else begin
            st_d.status = admit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign status_o = st_q.status;

    p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.status == '0));

    p_hold_while_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|st_q.status) && !clr_i) |=> $stable(st_q.status));

    p_promote_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.status == '0) && (st_q.shadow != '0) && !clr_i)
            |=> (st_q.status == $past(st_q.shadow)));

    p_masked_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.status == '0) && (st_q.shadow == '0) && !clr_i)
            |=> ((st_q.status & $past(mask_i)) == '0));

endmodule

// File: rtl/irq_shadow_rdmux.sv
module irq_shadow_rdmux
    import irq_shadow_pkg::*;
#(
    parameter int unsigned BANKS  = DEF_BANKS,
    parameter int unsigned WIDTH  = DEF_WIDTH,
    parameter int unsigned ADDR_W = $clog2(2 * BANKS)
) (
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [BANKS*WIDTH-1:0]      status_i,
    input  logic [BANKS-1:0][WIDTH-1:0] mask_i,
    output logic [WIDTH-1:0]            rdata_o
);

    always_comb begin
        rdata_o = '0;
        unique case (reg_kind(int'(addr_i), BANKS))
            REG_STATUS: rdata_o = status_i[int'(addr_i) * int'(WIDTH) +: WIDTH];
            REG_MASK:   rdata_o = mask_i[int'(addr_i) - int'(BANKS)];
            default:    rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_shadow_ctrl.sv
module irq_shadow_ctrl
    import irq_shadow_pkg::*;
#(
    parameter int unsigned BANKS  = DEF_BANKS,
    parameter int unsigned WIDTH  = DEF_WIDTH,
    parameter int unsigned ADDR_W = $clog2(2 * BANKS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [BANKS*WIDTH-1:0] evt_i,
    input  logic                   wr_en_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [WIDTH-1:0]       wdata_i,
    output logic [WIDTH-1:0]       rdata_o,
    output logic                   irq_n_o
);

    localparam int unsigned N = BANKS * WIDTH;

    logic [BANKS-1:0][WIDTH-1:0] mask_banks;
    logic [N-1:0]                mask_flat;
    logic [N-1:0]                status;
    logic                        clr;

    assign clr       = wr_en_i && (reg_kind(int'(addr_i), BANKS) == REG_STATUS);
    assign mask_flat = mask_banks;

    irq_shadow_mask #(.BANKS(BANKS), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_en_i),
        .addr_i (addr_i),
        .wdata_i(wdata_i),
        .mask_o (mask_banks)
    );

    irq_shadow_event #(.N(N)) u_event (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_i),
        .mask_i  (mask_flat),
        .clr_i   (clr),
        .status_o(status)
    );

    irq_shadow_rdmux #(.BANKS(BANKS), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_rdmux (
        .addr_i  (addr_i),
        .status_i(status),
        .mask_i  (mask_banks),
        .rdata_o (rdata_o)
    );

    assign irq_n_o = ~|(status & ~mask_flat);

    p_irq_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> irq_n_o);

endmodule

// File: tb/irq_shadow_ctrl_bench.sv
module irq_shadow_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] evt = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq_n;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    irq_shadow_ctrl u_irq_shadow_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_n_o(irq_n)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic chk_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [23:0] v);
        evt = v;
        step();
        evt = '0;
    endtask

    task automatic drain();
        wr(3'd0, 8'h00);
        step();
        wr(3'd0, 8'h00);
        step();
    endtask

    task automatic t_reset();
        chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
        for (int a = 0; a < 6; a++) chk_reg("R1 reg", 3'(a), 8'h00);
    endtask

    task automatic t_basic();
        pulse(24'h02_00_20);            // bit 5 and bit 17
        chk("R2 irq_n low", {7'd0, irq_n}, 8'h00);
        chk_reg("R11 status0", 3'd0, 8'h20);
        chk_reg("R11 status1", 3'd1, 8'h00);
        chk_reg("R11 status2", 3'd2, 8'h02);
        chk_reg("R10 reread status0", 3'd0, 8'h20);
        step();
        chk_reg("R10 status0 after reads", 3'd0, 8'h20);
        chk("R10 irq_n", {7'd0, irq_n}, 8'h00);
        // busy: bit 9 must go to shadow
        pulse(24'h00_02_00);
        chk_reg("R4 status1 held", 3'd1, 8'h00);
        chk_reg("R4 status0 held", 3'd0, 8'h20);
        wr(3'd1, 8'h5A);                // clear via a different status address
        chk("R5 irq_n high", {7'd0, irq_n}, 8'h01);
        chk_reg("R5 status0", 3'd0, 8'h00);
        chk_reg("R5 status2", 3'd2, 8'h00);
        step();
        chk_reg("R6 promoted status1", 3'd1, 8'h02);
        chk("R6 irq_n low", {7'd0, irq_n}, 8'h00);
        wr(3'd2, 8'hFF);
        step();
        chk("R6 no further promotion", {7'd0, irq_n}, 8'h01);
        chk_reg("R6 status1 empty", 3'd1, 8'h00);
    endtask

    task automatic t_unmapped();
        pulse(24'h00_00_02);
        wr(3'd7, 8'hFF);
        chk_reg("R5 unmapped write ignored", 3'd0, 8'h02);
        chk("R5 unmapped irq_n", {7'd0, irq_n}, 8'h00);
        drain();
    endtask

    task automatic t_mask();
        wr(3'd3, 8'h08);
        chk_reg("R9 mask readback", 3'd3, 8'h08);
        wr(3'd5, 8'hC3);
        chk_reg("R9 mask2 readback", 3'd5, 8'hC3);
        wr(3'd5, 8'h00);
        pulse(24'h00_00_08);            // masked bit 3
        chk("R3 irq_n stays high", {7'd0, irq_n}, 8'h01);
        chk_reg("R3 status0", 3'd0, 8'h00);
        wr(3'd0, 8'h00);
        step();
        chk_reg("R3 no shadow when idle", 3'd0, 8'h00);
        pulse(24'h00_00_01);            // busy
        pulse(24'h00_00_08);            // masked while busy
        wr(3'd0, 8'h00);
        step();
        chk_reg("R3 no shadow when busy", 3'd0, 8'h00);
        chk("R3 irq_n", {7'd0, irq_n}, 8'h01);
        wr(3'd3, 8'h00);
    endtask

    task automatic t_edges();
        pulse(24'h00_00_04);            // bit 2 -> busy
        pulse(24'h00_00_10);            // bit 4 -> shadow
        evt = 24'h00_10_00;             // bit 12 with the clear
        wr(3'd0, 8'h00);
        evt = 24'h10_00_00;             // bit 20 during promotion
        step();
        evt = '0;
        chk_reg("R7 clear-cycle event promoted", 3'd1, 8'h10);
        chk_reg("R7 shadow promoted", 3'd0, 8'h10);
        chk_reg("R7 promotion-cycle event held", 3'd2, 8'h00);
        wr(3'd0, 8'h00);
        step();
        chk_reg("R7 next round", 3'd2, 8'h10);
        chk("R7 irq_n", {7'd0, irq_n}, 8'h00);
        drain();
    endtask

    task automatic t_late_mask();
        pulse(24'h00_00_80);
        chk("R8 irq_n low", {7'd0, irq_n}, 8'h00);
        wr(3'd3, 8'h80);
        chk("R8 irq_n released by mask", {7'd0, irq_n}, 8'h01);
        chk_reg("R8 status kept", 3'd0, 8'h80);
        wr(3'd3, 8'h00);
        chk("R8 irq_n back low", {7'd0, irq_n}, 8'h00);
        drain();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic();
        t_unmapped();
        t_mask();
        t_edges();
        t_late_mask();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule